// File: doc/BRIEF.md
# Packed Fuse Record Decoder

This block rebuilds one window of a paged logical configuration map from a packed physical fuse image. The image sits in a byte-wide RAM with a one-cycle synchronous read port. It holds a chain of variable-length records. Each record is a short header followed by up to four 16-bit data words. The header names a page, a block index and a mask of the words that are present. The block walks this chain one byte at a time and writes the matching bytes into a byte-wide logical RAM through a registered write port.

A decode is started by a one-cycle `start` pulse, which captures the image size, the first byte to scan, a 32-bit window descriptor and the window length. The block first presets the window to the erased value. It then decodes records until it reaches an erased header byte or the end of the image, or until it finds a malformed record. It reports the end of the run with a one-cycle `done` pulse. `err` is valid together with that pulse and stays valid until the next start. A `start` that arrives while a run is in progress is not taken.

Top module: `fuse_rec_decoder`

## Requirements
- R1: The window descriptor holds the page id in bits 31:16 and the byte offset of the window inside that page in bits 15:0. Output address = logical address − offset.
- R2: After `start`, the block writes 0xFF to every window address, in ascending order from 0 to size−1. These writes come before any decoded byte is written.
- R3: The first header byte is read at `scan_start`. Bytes below that index are never decoded.
- R4: On pages other than 7, a header is three bytes forming {b0,b1,b2}. The page is in bits 19:17, the block index in bits 16:4 and the word mask in bits 3:0. If any of the three bytes is 0xFF, the scan ends normally (done, err low).
- R5: When the window page id is 7, every header is two bytes forming {b0,b1}, with the block index in bits 11:4 and the word mask in bits 3:0. The record counts as page 7. If either byte is 0xFF, the scan ends normally.
- R6: Mask bit w set to 1 means word w is absent. Present words follow the header in order w0 to w3 and take two bytes each, low byte first. The logical address of word w is block×8 + w×2.
- R7: A block index of MAX_BLK or more ends the run with err high.
- R8: A present word whose first byte index is at or beyond image size − 1 ends the run with err high. Words decoded before that point keep their writes.
- R9: A word is written only if its record page equals the window page and its logical address lies in [offset rounded down to even, offset+size rounded up to even).
- R10: If the window starts at an odd offset, only the high byte of its first word is written. If it ends at an odd address, only the low byte of its last word is written. In all other cases both bytes of the word are written.
- R11: After reset, done, err and the write strobe are low. Once a record completes and the scan index has reached the image size, the run ends normally with a single-cycle done and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode (taken only when idle) |
| phys_size | input | AW | Physical image size in bytes |
| scan_start | input | AW | Byte index of the first header |
| win_desc | input | 32 | Page id [31:16], page byte offset [15:0] |
| win_size | input | 16 | Window length in bytes |
| rd_addr | output | AW | Physical RAM read address |
| rd_data | input | 8 | Physical RAM data, one cycle after the address |
| wr_en | output | 1 | Logical RAM byte write strobe |
| wr_addr | output | 16 | Logical RAM byte address, relative to the window |
| wr_data | output | 8 | Logical RAM write data |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Malformed-record flag, valid with done |

## Verification
The embedded assertions check the following on every cycle: each write lands inside the captured window, the read pointer never advances by more than two bytes per cycle, `done` lasts a single cycle, and `err` can only rise together with `done`. Only the bench scenarios can show that header fields are decoded into the right logical addresses, that the page and range filters work, that odd window edges are clipped, that both header formats are parsed, and that each stop rule fires at the correct byte. The bench does this by predicting the whole ordered write stream for each image and comparing it against the stream the design actually produces.

// File: rtl/fuse_dec_pkg.sv
package fuse_dec_pkg;

  localparam int BLKW = 13;
  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_HA, S_HB, S_DEC, S_WCHK,
    S_D0A, S_D0B, S_D1A, S_D1B, S_WLO, S_WHI, S_NXT
  } dec_state_e;

  typedef struct packed {
    logic [15:0]     page;
    logic [BLKW-1:0] blk;
    logic [3:0]      wmask;
  } rec_hdr_t;

endpackage

// File: rtl/fuse_hdr_split.sv
module fuse_hdr_split
  import fuse_dec_pkg::*;
#(
  parameter int SHORT_PAGE = 7
) (
  input  logic       short_fmt,
  input  logic [3:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  output rec_hdr_t   hdr
);

  always_comb begin
    if (short_fmt) begin
      // two-byte form: {b0,b1}, block in 11:4, mask in 3:0
      hdr.page  = 16'(SHORT_PAGE);
      hdr.blk   = BLKW'({b0, b1[7:4]});
      hdr.wmask = b1[3:0];
    end else begin
      // three-byte form: {b0,b1,b2}, page 19:17, block 16:4, mask 3:0
      hdr.page  = {13'd0, b0[3:1]};
      hdr.blk   = {b0[0], b1, b2[7:4]};
      hdr.wmask = b2[3:0];
    end
  end

endmodule

// File: rtl/fuse_win_clip.sv
module fuse_win_clip #(
  parameter int LW = 16
) (
  input  logic [LW+1:0] laddr,
  input  logic [LW-1:0] off,
  input  logic [LW-1:0] wsize,
  input  logic          page_hit,
  output logic          hit,
  output logic          lo_en,
  output logic          hi_en,
  output logic [LW-1:0] lo_addr,
  output logic [LW-1:0] hi_addr
);

  logic [LW+1:0] lo_lim, wend, hi_lim;
  logic          first_w, last_w;

  assign lo_lim  = {2'b00, off[LW-1:1], 1'b0};
  assign wend    = {2'b00, off} + {2'b00, wsize};
  assign hi_lim  = wend + {{(LW+1){1'b0}}, wend[0]};
  assign hit     = page_hit && (laddr >= lo_lim) && (laddr < hi_lim);
  assign first_w = (laddr == lo_lim) && off[0];
  assign last_w  = ((laddr + (LW+2)'(2)) == hi_lim) && wend[0];
  assign lo_en   = hit && !first_w;
  assign hi_en   = hit && (first_w || !last_w);
  assign lo_addr = laddr[LW-1:0] - off;
  assign hi_addr = lo_addr + LW'(1);

endmodule

// File: rtl/fuse_rec_decoder.sv
module fuse_rec_decoder
  import fuse_dec_pkg::*;
#(
  parameter int AW         = 16,
  parameter int MAX_BLK    = 'h2000,
  parameter int SHORT_PAGE = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] phys_size,
  input  logic [AW-1:0] scan_start,
  input  logic [31:0]   win_desc,
  input  logic [15:0]   win_size,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [15:0]   wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          err
);

  localparam int LW = 16;
  localparam logic [BLKW:0] BLK_LIM = (BLKW+1)'(MAX_BLK);

  dec_state_e    st;
  logic [AW-1:0] ptr, psize_q;
  logic [15:0]   page_q;
  logic [LW-1:0] off_q, wsize_q, fill_cnt;
  logic [3:0]    h0;
  logic [7:0]    h1, h2, v0, v1;
  logic [1:0]    hidx, widx;
  logic          wr_en_q, done_q, err_q;
  logic [LW-1:0] wr_addr_q;
  logic [7:0]    wr_data_q;

  rec_hdr_t      hdr;
  logic          short_fmt, blk_bad, tail_short, more, present;
  logic [1:0]    hdr_last;
  logic [LW+1:0] laddr;
  logic          c_hit, c_lo, c_hi;
  logic [LW-1:0] c_lo_addr, c_hi_addr;

  assign short_fmt  = (page_q == 16'(SHORT_PAGE));
  assign hdr_last   = short_fmt ? 2'd1 : 2'd2;
  assign blk_bad    = {1'b0, hdr.blk} >= BLK_LIM;
  assign tail_short = ({1'b0, ptr} + (AW+1)'(1)) >= {1'b0, psize_q};
  assign more       = ptr < psize_q;
  assign present    = !hdr.wmask[widx];
  assign laddr      = {2'b00, hdr.blk, 3'b000} + {{(LW-1){1'b0}}, widx, 1'b0};

  fuse_hdr_split #(.SHORT_PAGE(SHORT_PAGE)) u_split (
    .short_fmt(short_fmt), .b0(h0), .b1(h1), .b2(h2), .hdr(hdr)
  );

  fuse_win_clip #(.LW(LW)) u_clip (
    .laddr(laddr), .off(off_q), .wsize(wsize_q),
    .page_hit(hdr.page == page_q),
    .hit(c_hit), .lo_en(c_lo), .hi_en(c_hi),
    .lo_addr(c_lo_addr), .hi_addr(c_hi_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;   ptr <= '0;   psize_q <= '0;  page_q <= '0;
      off_q <= '0;    wsize_q <= '0; fill_cnt <= '0;
      h0 <= '0; h1 <= '0; h2 <= '0; v0 <= '0; v1 <= '0;
      hidx <= '0; widx <= '0;
      wr_en_q <= 1'b0; wr_addr_q <= '0; wr_data_q <= '0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          psize_q  <= phys_size;
          ptr      <= scan_start;
          page_q   <= win_desc[31:16];
          off_q    <= win_desc[15:0];
          wsize_q  <= win_size;
          fill_cnt <= '0;
          hidx     <= '0;
          err_q    <= 1'b0;
          st       <= (win_size == '0) ? S_HA : S_FILL;
        end
        S_FILL: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= fill_cnt;
          wr_data_q <= ERASED;
          fill_cnt  <= fill_cnt + LW'(1);
          if (fill_cnt == wsize_q - LW'(1)) st <= S_HA;
        end
        S_HA: st <= S_HB;
        S_HB: begin
          if (rd_data == ERASED) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            case (hidx)
              2'd0:    h0 <= rd_data[3:0];
              2'd1:    h1 <= rd_data;
              default: h2 <= rd_data;
            endcase
            ptr <= ptr + AW'(1);
            if (hidx == hdr_last) st <= S_DEC;
            else begin
              hidx <= hidx + 2'd1;
              st   <= S_HA;
            end
          end
        end
        S_DEC: begin
          hidx <= '0;
          widx <= '0;
          if (blk_bad) begin
            err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
          end else st <= S_WCHK;
        end
        S_WCHK: begin
          if (!present) st <= S_NXT;
          else if (tail_short) begin
            err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
          end else if (c_hit) st <= S_D0A;
          else begin
            ptr <= ptr + AW'(2);
            st  <= S_NXT;
          end
        end
        S_D0A: st <= S_D0B;
        S_D0B: begin v0 <= rd_data; ptr <= ptr + AW'(1); st <= S_D1A; end
        S_D1A: st <= S_D1B;
        S_D1B: begin v1 <= rd_data; ptr <= ptr + AW'(1); st <= S_WLO; end
        S_WLO: begin
          wr_en_q <= c_lo; wr_addr_q <= c_lo_addr; wr_data_q <= v0;
          st <= S_WHI;
        end
        S_WHI: begin
          wr_en_q <= c_hi; wr_addr_q <= c_hi_addr; wr_data_q <= v1;
          st <= S_NXT;
        end
        S_NXT: begin
          if (widx == 2'd3) begin
            if (more) st <= S_HA;
            else begin
              done_q <= 1'b1; st <= S_IDLE;
            end
          end else begin
            widx <= widx + 2'd1;
            st   <= S_WCHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_addr = ptr;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign done    = done_q;
  assign err     = err_q;

  // R9
  wr_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr < wsize_q));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && $past(st) != S_IDLE) |-> ((ptr - $past(ptr)) <= AW'(2)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

endmodule

// File: tb/fuse_rec_decoder_test.sv
`timescale 1ns/1ps
module fuse_rec_decoder_test;

  localparam int MAXB  = 64;
  localparam int SPAGE = 7;

  logic        clk = 1'b0;
  logic        rst, start;
  logic [15:0] phys_size, scan_start, win_size;
  logic [31:0] win_desc;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        wr_en, done, err;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always #5 clk = ~clk;

  fuse_rec_decoder #(.AW(16), .MAX_BLK(MAXB), .SHORT_PAGE(SPAGE)) uut (
    .clk(clk), .rst(rst), .start(start), .phys_size(phys_size),
    .scan_start(scan_start), .win_desc(win_desc), .win_size(win_size),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err)
  );

  logic [7:0]  img [0:511];
  always @(posedge clk) rd_data <= img[rd_addr[8:0]];

  int          checks = 0, errors = 0, wp = 0;
  string       tag = "R11";
  logic [23:0] expq [$];

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s extra write actual %04h:%02h expected none", tag, wr_addr, wr_data);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          errors++;
          $display("FAIL %s write actual %04h:%02h expected %04h:%02h",
                   tag, wr_addr, wr_data, e[23:8], e[7:0]);
        end
      end
    end
  end

  task automatic clr_img();
    for (int i = 0; i < 512; i++) img[i] = 8'hFF;
    wp = 0;
  endtask

  task automatic put_hdr(input int pg, input int blk, input logic [3:0] m);
    logic [23:0] h;
    h = {4'h0, 3'(pg), 13'(blk), m};
    img[wp] = h[23:16]; img[wp+1] = h[15:8]; img[wp+2] = h[7:0];
    wp += 3;
  endtask

  task automatic put_shdr(input int blk, input logic [3:0] m);
    logic [7:0] b;
    b = 8'(blk);
    img[wp] = {4'h0, b[7:4]}; img[wp+1] = {b[3:0], m};
    wp += 2;
  endtask

  task automatic put_word(input logic [15:0] v);
    img[wp] = v[7:0]; img[wp+1] = v[15:8];
    wp += 2;
  endtask

  // expected write stream derived from the requirements
  task automatic model(input int psize, input int sstart, input logic [31:0] desc,
                       input int wsize, output bit eerr);
    int page, off, mn, mx, p, bp, bi, li;
    logic [3:0] m;
    page = int'(desc[31:16]); off = int'(desc[15:0]);
    mn = off & ~1; mx = (off + wsize + 1) & ~1;
    eerr = 1'b0;
    for (int i = 0; i < wsize; i++) expq.push_back({16'(i), 8'hFF});   // R2
    p = sstart;                                                        // R3
    do begin
      if (page == SPAGE) begin                                         // R5
        if (img[p] == 8'hFF || img[p+1] == 8'hFF) break;
        bp = SPAGE; bi = int'({img[p][3:0], img[p+1][7:4]}); m = img[p+1][3:0];
        p += 2;
      end else begin                                                   // R4
        if (img[p] == 8'hFF || img[p+1] == 8'hFF || img[p+2] == 8'hFF) break;
        bp = int'(img[p][3:1]); bi = int'({img[p][0], img[p+1], img[p+2][7:4]});
        m = img[p+2][3:0];
        p += 3;
      end
      if (bi >= MAXB) begin eerr = 1'b1; return; end                   // R7
      for (int w = 0; w < 4; w++) begin
        if (m[w]) continue;                                            // R6
        if (p >= psize - 1) begin eerr = 1'b1; return; end             // R8
        li = bi * 8 + w * 2;
        if (bp == page && li >= mn && li < mx) begin                   // R9
          if (li == mn && off > mn)
            expq.push_back({16'(li - off + 1), img[p+1]});             // R10
          else if (li + 2 == mx && off + wsize < mx)
            expq.push_back({16'(li - off), img[p]});
          else begin
            expq.push_back({16'(li - off), img[p]});
            expq.push_back({16'(li - off + 1), img[p+1]});
          end
        end
        p += 2;
      end
    end while (p < psize);                                             // R11
  endtask

  task automatic run(input string t, input int psize, input int sstart,
                     input int pg, input int off, input int wsize);
    bit eerr;
    int n;
    tag = t;
    model(psize, sstart, {16'(pg), 16'(off)}, wsize, eerr);
    @(negedge clk);
    phys_size = 16'(psize); scan_start = 16'(sstart);
    win_desc = {16'(pg), 16'(off)}; win_size = 16'(wsize);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s done actual 0 expected 1", t);
    end
    checks++;
    if (err !== eerr) begin
      errors++;
      $display("FAIL %s err actual %0b expected %0b", t, err, eerr);
    end
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing writes actual %0d left expected 0", t, expq.size());
      expq.delete();
    end
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL R11 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    phys_size = '0; scan_start = '0; win_desc = '0; win_size = '0;
    clr_img();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    checks++;
    if (wr_en !== 1'b0 || done !== 1'b0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs actual %0b%0b%0b expected 000", wr_en, done, err);
    end

    // R1 R2 R4 R6 R9: full words, a foreign page, a partial mask, stop at erased header byte
    clr_img();
    put_hdr(1, 0, 4'b0000);
    put_word(16'h1211); put_word(16'h2221); put_word(16'h3231); put_word(16'h4241);
    put_hdr(2, 0, 4'b0000);
    put_word(16'h5251); put_word(16'h5453); put_word(16'h5655); put_word(16'h5857);
    put_hdr(1, 1, 4'b1010);
    put_word(16'hA1A0); put_word(16'hB1B0);
    img[wp] = 8'h02; img[wp+1] = 8'hFF; img[wp+2] = 8'h00; wp += 3;
    put_hdr(1, 1, 4'b1101); put_word(16'hEEEE);
    run("R4_R6_R9", 64, 0, 1, 0, 16);

    // R10: odd start and odd end
    run("R10_odd_edges", 64, 0, 1, 3, 6);
    // R10: single-byte windows at odd and even offsets
    run("R10_one_odd", 64, 0, 1, 9, 1);
    run("R10_one_even", 64, 0, 1, 12, 1);
    // R9: window on a page with no records
    run("R9_other_page", 64, 0, 3, 0, 4);

    // R5: short headers on page 7
    clr_img();
    put_shdr(1, 4'b0110); put_word(16'hC1C0); put_word(16'hC7C6);
    put_shdr(0, 4'b0000);
    put_word(16'hD1D0); put_word(16'hD3D2); put_word(16'hD5D4); put_word(16'hD7D6);
    run("R5_short_hdr", 64, 0, SPAGE, 0, 16);

    // R3: scan begins past a leading region that would otherwise decode
    clr_img();
    img[0] = 8'h02; img[1] = 8'h00; img[2] = 8'h00; img[3] = 8'h13;
    wp = 4;
    put_hdr(1, 0, 4'b1110); put_word(16'h5A6B);
    run("R3_scan_start", 64, 4, 1, 0, 8);

    // R7: block index at the limit
    clr_img();
    put_hdr(1, 0, 4'b1110); put_word(16'h0102);
    put_hdr(1, MAXB, 4'b0000); put_word(16'h0304);
    run("R7_blk_limit", 64, 0, 1, 0, 4);

    // R8: second present word starts at size - 1
    clr_img();
    put_hdr(1, 0, 4'b1100); put_word(16'h6261); put_word(16'h6463);
    run("R8_truncated", 6, 0, 1, 0, 4);

    // R11: ends exactly at the image size with valid bytes beyond it
    clr_img();
    put_hdr(1, 0, 4'b1110); put_word(16'h7170);
    put_hdr(1, 0, 4'b1101); put_word(16'h7777);
    run("R11_size_end", 5, 0, 1, 0, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule